// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block walks a pixel-clock raster and produces horizontal sync, vertical sync, a data-enable window, a field indicator and a one-clock start-of-frame strobe. All geometry comes from a small write-only register set. Each register holds last-index totals or active-window edges, never porch widths. Software derives each value from the porch and sync figures of the wanted mode. It loads the registers while the block is stopped and then starts it. Interlaced rasters use a second set of vertical registers for the odd field.

The raster is driven by a three-state controller. `ST_OFF` holds both counters at zero and keeps every output inactive. `ST_FIELD1` walks the first (or only) field. `ST_FIELD2` walks the second field of an interlaced frame. The transitions are:
- **start**: `ST_OFF` to `ST_FIELD1` when the enable register is set.
- **stop**: either field state to `ST_OFF` when the enable register is cleared.
- **field swap**: `ST_FIELD1` to `ST_FIELD2` at a vertical wrap when interlace is selected.
- **field return**: `ST_FIELD2` to `ST_FIELD1` at its own vertical wrap.
- **frame repeat**: `ST_FIELD1` stays in `ST_FIELD1` at a vertical wrap in progressive mode.

Packed position fields are 13 bits wide. A write that sets bits outside those fields is refused and raises a sticky error flag.

Top module: `vtg_top`

## Requirements
- R1: After reset, de, frame_start, field, hsync, vsync and err_flag are all 0.
- R2: Register addresses and layout:
  - Address 0 holds the vertical last index in bits 28:16 and the horizontal last index in bits 12:0.
  - Address 1 holds the horizontal active end in bits 28:16 and the horizontal active start in bits 12:0.
  - Address 2 holds the field-1 vertical active end in bits 28:16 and the field-1 vertical active start in bits 12:0.
  - Address 3 holds the field-2 vertical last index in bits 12:0.
  - Address 4 holds the field-2 vertical active end in bits 28:16 and the field-2 vertical active start in bits 12:0.
  - Address 5 is frame control: bit 31 selects interlace, bit 29 makes hsync active low, bit 28 makes vsync active low, bits 27:16 give the vsync width in lines and bits 11:0 give the hsync width in pixels.
  - Address 6 is the enable register.
  - Address 7 is ignored.
- R3: A write to addresses 0 to 4 with any of bits 31:29 or 15:13 set leaves the register unchanged. It sets err_flag on the following clock edge.
- R4: err_flag stays set until a clock edge with err_rd high clears it. If a refused write and err_rd fall on the same edge, err_flag ends set.
- R5: Writing a value whose bits 1:0 are both 1 to address 6 starts the raster. Writing any other value to address 6 stops it.
  - Start: frame_start is high in the second clock cycle after the write edge.
  - Stop: one cycle after the stop write, de, frame_start and field are 0 and both syncs sit at their inactive level.
- R6: The horizontal count runs from 0 to the horizontal last index. The vertical count advances when the horizontal count wraps and runs from 0 to the last index of the current field.
- R7: de is high when the horizontal count h satisfies start <= h < end and the vertical count v satisfies start < v <= end. The vertical start and end come from the current field's registers.
- R8: Each sync is active for counts 0 through width-1 of its own counter and is inverted when its active-low bit is set.
- R9: frame_start is high for exactly the cycle in which both counts are 0, including the first cycle after start.
- R10: With interlace selected, field toggles at every vertical wrap. Field 2 uses the address 3 and address 4 values. In progressive mode field stays 0.
- R11: Writes to addresses 0 to 5 while the raster is enabled have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| err_rd | input | 1 | Read strobe for the error flag; clears it |
| err_flag | output | 1 | Sticky flag for a refused out-of-range write |
| hsync | output | 1 | Horizontal sync, polarity per frame control |
| vsync | output | 1 | Vertical sync, polarity per frame control |
| de | output | 1 | Active-video data enable |
| field | output | 1 | 0 for field 1, 1 for field 2 |
| frame_start | output | 1 | One-cycle strobe at count origin |

## Verification
The checker watches several invariants on every cycle:
- err_flag holds until it is read, and it rises only after a write.
- The stopped state keeps de, frame_start and field low.
- Both counters stay within their programmed last index.
- Each frame_start that follows a running cycle comes right after a horizontal wrap.
- field stays 0 in progressive mode.

Some behaviour only the bench scenarios can show: the exact de window and sync widths for each programmed mode, the polarity inversions, the field-2 geometry, that a refused or late write leaves the raster unchanged, and the start and stop latency. The bench covers these by comparing every output on every cycle against a counter model built from the porch figures. It runs both random small modes and a standard 720-line progressive mode.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FIELD1 = 2'd1,
        ST_FIELD2 = 2'd2
    } vtg_state_e;

    typedef enum logic [2:0] {
        RA_TOTAL      = 3'd0,
        RA_ACT_H      = 3'd1,
        RA_ACT_V      = 3'd2,
        RA_F2_TOTAL   = 3'd3,
        RA_F2_ACT_V   = 3'd4,
        RA_FRAME_CTRL = 3'd5,
        RA_ENABLE     = 3'd6,
        RA_SPARE      = 3'd7
    } vtg_reg_e;

    localparam int unsigned HI_LSB    = 16;
    localparam int unsigned BIT_ILACE = 31;
    localparam int unsigned BIT_HNEG  = 29;
    localparam int unsigned BIT_VNEG  = 28;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned POS_W  = 13,
    parameter int unsigned SYNC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              err_rd,
    output logic [POS_W-1:0]  total_h,
    output logic [POS_W-1:0]  total_v,
    output logic [POS_W-1:0]  h_start,
    output logic [POS_W-1:0]  h_end,
    output logic [POS_W-1:0]  v1_start,
    output logic [POS_W-1:0]  v1_end,
    output logic [POS_W-1:0]  f2_total_v,
    output logic [POS_W-1:0]  v2_start,
    output logic [POS_W-1:0]  v2_end,
    output logic              ilace,
    output logic              hneg,
    output logic              vneg,
    output logic [SYNC_W-1:0] hs_width,
    output logic [SYNC_W-1:0] vs_width,
    output logic              enable,
    output logic              err_flag
);

    localparam logic [15:0] HALF_MASK  = 16'((32'd1 << POS_W) - 32'd1);
    localparam logic [31:0] FIELD_MASK = {HALF_MASK, HALF_MASK};

    vtg_reg_e   addr;
    logic       fits;
    logic       checked;
    logic       refuse;
    logic       accept;

    always_comb begin
        addr    = vtg_reg_e'(wr_addr);
        fits    = (wr_data & ~FIELD_MASK) == 32'd0;
        checked = (wr_addr <= 3'd4);
        refuse  = wr_en && checked && !fits;
        accept  = wr_en && !enable && (fits || !checked);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_h    <= '0;
            total_v    <= '0;
            h_start    <= '0;
            h_end      <= '0;
            v1_start   <= '0;
            v1_end     <= '0;
            f2_total_v <= '0;
            v2_start   <= '0;
            v2_end     <= '0;
            ilace      <= 1'b0;
            hneg       <= 1'b0;
            vneg       <= 1'b0;
            hs_width   <= '0;
            vs_width   <= '0;
            enable     <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            if (err_rd) err_flag <= 1'b0;
            if (refuse) err_flag <= 1'b1;
            if (wr_en && addr == RA_ENABLE) begin
                enable <= (wr_data[1:0] == 2'b11);
            end
            if (accept) begin
                case (addr)
                    RA_TOTAL: begin
                        total_v <= wr_data[HI_LSB +: POS_W];
                        total_h <= wr_data[0 +: POS_W];
                    end
                    RA_ACT_H: begin
                        h_end   <= wr_data[HI_LSB +: POS_W];
                        h_start <= wr_data[0 +: POS_W];
                    end
                    RA_ACT_V: begin
                        v1_end   <= wr_data[HI_LSB +: POS_W];
                        v1_start <= wr_data[0 +: POS_W];
                    end
                    RA_F2_TOTAL: f2_total_v <= wr_data[0 +: POS_W];
                    RA_F2_ACT_V: begin
                        v2_end   <= wr_data[HI_LSB +: POS_W];
                        v2_start <= wr_data[0 +: POS_W];
                    end
                    RA_FRAME_CTRL: begin
                        ilace    <= wr_data[BIT_ILACE];
                        hneg     <= wr_data[BIT_HNEG];
                        vneg     <= wr_data[BIT_VNEG];
                        vs_width <= wr_data[HI_LSB +: SYNC_W];
                        hs_width <= wr_data[0 +: SYNC_W];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
    import vtg_pkg::*;
#(
    parameter int unsigned POS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ilace,
    input  logic [POS_W-1:0] total_h,
    input  logic [POS_W-1:0] total_v,
    input  logic [POS_W-1:0] f2_total_v,
    output vtg_state_e       state,
    output logic [POS_W-1:0] h_cnt,
    output logic [POS_W-1:0] v_cnt
);

    vtg_state_e       state_d;
    logic             h_wrap;
    logic             v_wrap;
    logic [POS_W-1:0] v_last;

    always_comb begin
        v_last = (state == ST_FIELD2) ? f2_total_v : total_v;
        h_wrap = (h_cnt == total_h);
        v_wrap = h_wrap && (v_cnt == v_last);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_d;
    end

    // transitions: start, stop, field swap, field return, frame repeat
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF: begin
                if (enable) state_d = ST_FIELD1;
            end
            ST_FIELD1: begin
                if (!enable)              state_d = ST_OFF;
                else if (v_wrap && ilace) state_d = ST_FIELD2;
            end
            ST_FIELD2: begin
                if (!enable)    state_d = ST_OFF;
                else if (v_wrap) state_d = ST_FIELD1;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (state == ST_OFF || state_d == ST_OFF) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_wrap) begin
            h_cnt <= '0;
            v_cnt <= v_wrap ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned POS_W  = 13,
    parameter int unsigned SYNC_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        err_rd,
    output logic        err_flag,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        field,
    output logic        frame_start
);

    localparam int unsigned PAD_W = POS_W - SYNC_W;
    localparam int unsigned N_AXIS = 2;

    logic [POS_W-1:0]  total_h, total_v, f2_total_v;
    logic [POS_W-1:0]  h_start, h_end, v1_start, v1_end, v2_start, v2_end;
    logic              ilace, hneg, vneg, enable;
    logic [SYNC_W-1:0] hs_width, vs_width;
    vtg_state_e        state;
    logic [POS_W-1:0]  h_cnt, v_cnt;
    logic              running;

    vtg_regs #(.POS_W(POS_W), .SYNC_W(SYNC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_rd(err_rd),
        .total_h(total_h), .total_v(total_v), .h_start(h_start), .h_end(h_end),
        .v1_start(v1_start), .v1_end(v1_end), .f2_total_v(f2_total_v),
        .v2_start(v2_start), .v2_end(v2_end), .ilace(ilace), .hneg(hneg),
        .vneg(vneg), .hs_width(hs_width), .vs_width(vs_width),
        .enable(enable), .err_flag(err_flag)
    );

    vtg_raster #(.POS_W(POS_W)) u_raster (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ilace(ilace),
        .total_h(total_h), .total_v(total_v), .f2_total_v(f2_total_v),
        .state(state), .h_cnt(h_cnt), .v_cnt(v_cnt)
    );

    logic [POS_W-1:0] axis_cnt   [N_AXIS];
    logic [POS_W-1:0] axis_width [N_AXIS];
    logic             axis_neg   [N_AXIS];
    logic             axis_sync  [N_AXIS];

    always_comb begin
        axis_cnt[0]   = h_cnt;
        axis_cnt[1]   = v_cnt;
        axis_width[0] = {{PAD_W{1'b0}}, hs_width};
        axis_width[1] = {{PAD_W{1'b0}}, vs_width};
        axis_neg[0]   = hneg;
        axis_neg[1]   = vneg;
    end

    for (genvar g = 0; g < N_AXIS; g++) begin : g_sync
        assign axis_sync[g] = (running && (axis_cnt[g] < axis_width[g])) ^ axis_neg[g];
    end

    // output decode from state and counters
    logic [POS_W-1:0] vs_sel, ve_sel;
    always_comb begin
        running     = (state != ST_OFF);
        field       = (state == ST_FIELD2);
        vs_sel      = field ? v2_start : v1_start;
        ve_sel      = field ? v2_end   : v1_end;
        de          = running && (h_cnt >= h_start) && (h_cnt < h_end)
                      && (v_cnt > vs_sel) && (v_cnt <= ve_sel);
        frame_start = running && (h_cnt == '0) && (v_cnt == '0);
        hsync       = axis_sync[0];
        vsync       = axis_sync[1];
    end

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int unsigned POS_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             err_rd,
    input logic             err_flag,
    input logic             de,
    input logic             frame_start,
    input logic             field,
    input logic             running,
    input logic             ilace,
    input logic [POS_W-1:0] h_cnt,
    input logic [POS_W-1:0] v_cnt,
    input logic [POS_W-1:0] total_h,
    input logic [POS_W-1:0] total_v
);

    p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_rd |=> err_flag);

    p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(wr_en));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!de && !frame_start && !field));

    p_hcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (h_cnt <= total_h));

    p_vcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !field) |-> (v_cnt <= total_v));

    p_fs_after_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && frame_start) |-> ($past(h_cnt) == $past(total_h)));

    p_field_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ilace) |-> !field);

endmodule

bind vtg_top vtg_checker #(.POS_W(POS_W)) u_vtg_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .err_rd(err_rd),
    .err_flag(err_flag), .de(de), .frame_start(frame_start), .field(field),
    .running(running), .ilace(ilace), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .total_h(total_h), .total_v(total_v)
);

// File: tb/test_vtg_top.sv
`timescale 1ns/1ps
module test_vtg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        err_rd = 1'b0;
    logic        err_flag, hsync, vsync, de, field, frame_start;

    always #2 clk = ~clk;

    vtg_top i_vtg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_rd(err_rd), .err_flag(err_flag),
        .hsync(hsync), .vsync(vsync), .de(de), .field(field),
        .frame_start(frame_start)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the programmed mode
    int m_htot, m_hs, m_he, m_vtot, m_vs, m_ve, m_v2tot, m_v2s, m_v2e;
    int m_hw, m_vw;
    bit m_il, m_hn, m_vn;
    int mh, mv;
    bit mf;
    logic mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_de(int h, int v, bit f);
        bit hin = (h >= m_hs) && (h < m_he);
        bit vin = f ? (v > m_v2s && v <= m_v2e) : (v > m_vs && v <= m_ve);
        return hin && vin;
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            chk(de == exp_de(mh, mv, mf), "R7 de", int'(de), int'(exp_de(mh, mv, mf)));
            chk(hsync == ((mh < m_hw) ^ m_hn), "R8 hsync", int'(hsync), int'((mh < m_hw) ^ m_hn));
            chk(vsync == ((mv < m_vw) ^ m_vn), "R8 vsync", int'(vsync), int'((mv < m_vw) ^ m_vn));
            chk(frame_start == (mh == 0 && mv == 0), "R9 frame_start", int'(frame_start), int'(mh == 0 && mv == 0));
            chk(field == mf, "R10 field", int'(field), int'(mf));
            if (mh == m_htot) begin
                mh = 0;
                if (mv == (mf ? m_v2tot : m_vtot)) begin
                    mv = 0;
                    mf = m_il ? ~mf : 1'b0;
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: register packing built from porch figures
    task automatic program_mode(int ha, int hf, int hw, int hb,
                                int va, int vf, int vw, int vb,
                                bit il, bit hn, bit vn);
        logic [31:0] fc;
        m_htot = ha + hf + hb + hw - 1;
        m_hs   = hb + hw;
        m_he   = m_htot + 1 - hf;
        m_vtot = va + vf + vb + vw - 1;
        m_vs   = vb + vw - 1;
        m_ve   = m_vtot - vf;
        m_v2tot = il ? m_vtot + 1 : 0;
        m_v2s   = il ? m_vs + 1 : 0;
        m_v2e   = il ? m_ve + 1 : 0;
        m_il = il; m_hn = hn; m_vn = vn; m_hw = hw; m_vw = vw;
        fc = '0;
        fc[31] = il; fc[29] = hn; fc[28] = vn;
        fc[27:16] = 12'(vw); fc[11:0] = 12'(hw);
        wr(3'd0, (m_vtot << 16) | m_htot);
        wr(3'd1, (m_he << 16) | m_hs);
        wr(3'd2, (m_ve << 16) | m_vs);
        wr(3'd3, m_v2tot);
        wr(3'd4, (m_v2e << 16) | m_v2s);
        wr(3'd5, fc);
    endtask

    // R5: start, then the monitor expects frame_start on the next negedge
    task automatic start_raster();
        wr(3'd6, 32'h3);
        chk(frame_start == 1'b0 && de == 1'b0, "R5 start latency", int'(frame_start), 0);
        mh = 0; mv = 0; mf = 1'b0;
        mon_on <= 1'b1;
    endtask

    task automatic stop_raster();
        wr(3'd6, 32'h0);
        mon_on <= 1'b0;
        @(negedge clk);
        chk(de == 1'b0, "R5 idle de", int'(de), 0);
        chk(frame_start == 1'b0, "R5 idle frame_start", int'(frame_start), 0);
        chk(field == 1'b0, "R5 idle field", int'(field), 0);
        chk(hsync == m_hn, "R5 idle hsync", int'(hsync), int'(m_hn));
        chk(vsync == m_vn, "R5 idle vsync", int'(vsync), int'(m_vn));
    endtask

    task automatic clear_err();
        @(negedge clk); err_rd = 1'b1;
        @(negedge clk); err_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=190000 cycles expected=fewer");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_hn = 0; m_vn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(de == 0, "R1 de", int'(de), 0);
        chk(frame_start == 0, "R1 frame_start", int'(frame_start), 0);
        chk(field == 0, "R1 field", int'(field), 0);
        chk(hsync == 0 && vsync == 0, "R1 syncs", int'({hsync, vsync}), 0);
        chk(err_flag == 0, "R1 err_flag", int'(err_flag), 0);

        // R3 refused write sets the flag; R4 read clears it
        wr(3'd0, 32'h0000_2000);
        chk(err_flag == 1, "R3 err on bit13", int'(err_flag), 1);
        @(negedge clk);
        chk(err_flag == 1, "R4 sticky", int'(err_flag), 1);
        clear_err();
        chk(err_flag == 0, "R4 cleared by read", int'(err_flag), 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h2000_0000; err_rd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; err_rd = 1'b0;
        chk(err_flag == 1, "R4 set wins over read", int'(err_flag), 1);
        clear_err();
        wr(3'd5, 32'hFFFF_0000);
        chk(err_flag == 0, "R3 frame ctrl unchecked", int'(err_flag), 0);
        wr(3'd7, 32'hFFFF_FFFF);
        chk(err_flag == 0, "R2 spare address ignored", int'(err_flag), 0);

        // 720-line progressive mode, first 30 lines
        program_mode(1280, 110, 40, 220, 720, 5, 5, 20, 1'b0, 1'b0, 1'b0);
        chk(err_flag == 0, "R3 in-range 720p accepted", int'(err_flag), 0);
        start_raster();
        repeat (30 * 1650) @(negedge clk);
        stop_raster();

        // directed: refused writes leave the mode intact (R3)
        program_mode(6, 2, 2, 3, 4, 1, 2, 2, 1'b1, 1'b1, 1'b0);
        wr(3'd0, 32'h4000_0005);
        wr(3'd1, 32'h0000_8003);
        chk(err_flag == 1, "R3 refused writes flagged", int'(err_flag), 1);
        clear_err();
        start_raster();
        repeat (4 * (m_htot + 1) * (m_vtot + 2)) @(negedge clk);
        stop_raster();

        // random modes, with late writes while enabled (R11)
        for (int k = 0; k < 6; k++) begin
            bit il, hn, vn;
            il = (k == 1) ? 1'b1 : (k == 0) ? 1'b0 : 1'($urandom_range(1, 0));
            hn = 1'($urandom_range(1, 0));
            vn = 1'($urandom_range(1, 0));
            program_mode($urandom_range(12, 4), $urandom_range(4, 1),
                         $urandom_range(3, 1), $urandom_range(4, 1),
                         $urandom_range(10, 2), $urandom_range(3, 1),
                         $urandom_range(3, 1), $urandom_range(3, 1),
                         il, hn, vn);
            start_raster();
            repeat (3 * (m_htot + 1) * (m_vtot + 2)) @(negedge clk);
            // R11: timing writes during run are ignored
            wr(3'd0, ((m_vtot + 3) << 16) | (m_htot + 2));
            wr(3'd1, 32'h0000_0000);
            wr(3'd5, {~m_il, 1'b0, ~m_hn, ~m_vn, 28'h0010_003});
            repeat (2 * (m_htot + 1) * (m_vtot + 2)) @(negedge clk);
            stop_raster();
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule